// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block runs the external memory bus of a small microcontroller, where one 8-bit port carries first an address byte and then the data byte. It runs from a fast clock at twice the oscillator rate, so one oscillator period is two ticks and half-period edges fall on tick boundaries. A core hands it requests (program fetch, data read, data write) with a 16-bit address. For each request the block frames an address phase marked by the latch strobe `ale`, then a strobe phase. Program fetches use the active-low `psen_n`. Data reads use `rd_n` and data writes use `wr_n`. It returns the sampled byte with a one-tick `rsp_done` pulse.

Requests use a valid/ready handshake. A request is taken on a tick where `req_valid` and `req_ready` are both high. `req_ready` only rises while the bus is idle or on the last strobe tick of the current frame, which lets frames run back to back. The core must hold the request stable while waiting. The response has no back-pressure: the core must take `rsp_rdata` on the tick that `rsp_done` is high.

There are two fetch layouts. The default frame lasts 8 ticks (4 oscillator periods). In page mode the port and the upper-byte output swap roles during fetches. A fetch whose upper address byte matches the open page skips the address phase and keeps `psen_n` low across the fetches.

Top module: `ext_bus_seq`

## Requirements
- R1: A default-mode fetch frame lasts 8 ticks. `ale` is high for its first 3 ticks and low for the remaining 5. Consecutive frames start 8 ticks apart.
- R2: In a full frame, the port is driven (`port_oe`=1) with `addr[7:0]` during the 3 `ale` ticks and the one hold tick that follows. `addr_hi` shows `addr[15:8]` from the first tick of the frame until the next frame starts.
- R3: A fetch drives `psen_n` low for the last 4 ticks of its frame, with `port_oe`=0. `psen_n` is high whenever no fetch strobe is in progress.
- R4: `req_kind` encoding: 0 is fetch, 1 is data read, 2 is data write, and the reserved value 3 acts as a data read. Data accesses always use the full frame. Across the last 4 ticks, a read holds `rd_n` low with the port released, and a write holds `wr_n` low while driving `req_wdata` with `port_oe`=1. At most one of the three strobes is low at a time.
- R5: At the edge that ends the last strobe tick, `port_in` is captured for reads and fetches. `rsp_done` is high for exactly the next tick, with `rsp_rdata` holding the captured byte. A write also pulses `rsp_done` and leaves `rsp_rdata` unchanged.
- R6: `req_ready` is high when idle or on the last strobe tick, and low otherwise. A request is taken only on valid and ready. A request taken on a last strobe tick starts its frame on the next tick with no gap.
- R7: A page-mode fetch that misses has `ale` high for 2 ticks, with the port driving `addr[15:8]`, and then 4 `psen_n` ticks with no hold tick. During the whole frame, `addr_hi` shows `addr[7:0]`.
- R8: A page-mode fetch whose upper byte equals the upper byte of the previous page-mode fetch, with the page still open, is a hit. It has no `ale` phase and only 4 `psen_n` ticks. Back-to-back hits keep `psen_n` low without a break.
- R9: A data access, or a fetch taken while `page_mode` is 0, closes the page. The next page-mode fetch is then a miss.
- R10: While the bus is idle, `ale` is held high if `emi_quiet`=1. Otherwise, if `idle_ale_en`=1, `ale` is high for ticks 0 to 2 of a free-running 8-tick count started at reset release. Otherwise it is low. During frames `ale` follows the frame whatever these inputs hold.
- R11: While `rst` is high, `ale`=1, `port_oe`=0, all strobes are high and `req_ready`=0. After reset, `rsp_done`=0, `rsp_rdata`=0 and `addr_hi`=0, and the page is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Fast clock, twice the oscillator rate |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this tick |
| req_kind | input | 2 | 0 fetch, 1 data read, 2 data write, 3 read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| page_mode | input | 1 | Page fetch layout select |
| idle_ale_en | input | 1 | Let `ale` pulse while idle |
| emi_quiet | input | 1 | Hold `ale` high while idle |
| rsp_done | output | 1 | One-tick completion pulse |
| rsp_rdata | output | 8 | Captured read byte |
| ale | output | 1 | Address latch strobe |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| port_oe | output | 1 | Shared port output enable (all bits driven) |
| port_out | output | 8 | Shared port drive value |
| port_in | input | 8 | Shared port sampled value |
| addr_hi | output | 8 | Upper address byte (low byte on page fetches) |

## Verification
The assertions watch on every tick for properties that need no knowledge of the request history. The port is released under any fetch strobe, and no two strobes overlap. A completion pulse lasts one tick and always follows a strobe. While `ale` marks an address phase the port is driven, and the reset values are held. The layouts that depend on history can only be shown by the bench's scenarios, which run against a tick-by-tick model. These are the 3/1/4 and 2/4 frame shapes, page hits with an unbroken `psen_n`, page closing by data accesses or mode changes, the alignment of the idle pulse train with reset, and the captured read bytes.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 2 * BUS_W;

  typedef enum logic [1:0] {K_FETCH = 2'd0, K_DRD = 2'd1, K_DWR = 2'd2} kind_e;
  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_HOLD, S_STRB} st_e;

  typedef struct packed {
    kind_e             kind;
    logic              pg;     // page-layout fetch
    logic              skip;   // page hit: no address phase
    logic [ADDR_W-1:0] addr;
    logic [BUS_W-1:0]  wdata;
  } frame_t;
endpackage

// File: rtl/ebs_page_track.sv
module ebs_page_track #(
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic            is_fetch,
  input  logic            page_mode,
  input  logic [HI_W-1:0] hi,
  output logic            hit
);
  logic            open_q;
  logic [HI_W-1:0] page_q;

  assign hit = page_mode && is_fetch && open_q && (hi == page_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      page_q <= '0;
    end else if (take) begin
      if (page_mode && is_fetch) begin
        open_q <= 1'b1;
        page_q <= hi;
      end else begin
        open_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ebs_idle_strobe.sv
module ebs_idle_strobe #(
  parameter int PERIOD = 8,
  parameter int HIGH   = 3
) (
  input  logic clk,
  input  logic rst,
  output logic pulse
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                        cnt <= '0;
    else if (cnt == CW'(PERIOD-1))  cnt <= '0;
    else                            cnt <= cnt + 1'b1;
  end

  assign pulse = (cnt < CW'(HIGH));
endmodule

// File: rtl/ebs_frame_seq.sv
module ebs_frame_seq
  import ebs_pkg::*;
#(
  parameter int ADDR_FULL = 3,
  parameter int ADDR_PAGE = 2,
  parameter int HOLD_T    = 1,
  parameter int STRB_T    = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  frame_t nxt,
  output st_e    st,
  output frame_t cur,
  output logic   last
);
  localparam int  M1   = (ADDR_FULL > ADDR_PAGE) ? ADDR_FULL : ADDR_PAGE;
  localparam int  M2   = (HOLD_T > STRB_T) ? HOLD_T : STRB_T;
  localparam int  MAXT = (M1 > M2) ? M1 : M2;
  localparam int  CW   = (MAXT > 1) ? $clog2(MAXT) : 1;
  localparam st_e FULL_NEXT = (HOLD_T == 0) ? S_STRB : S_HOLD;

  logic [CW-1:0] cnt;
  logic [CW-1:0] alen_m1;

  assign alen_m1 = cur.pg ? CW'(ADDR_PAGE-1) : CW'(ADDR_FULL-1);
  assign last    = (st == S_STRB) && (cnt == CW'(STRB_T-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_IDLE;
      cnt <= '0;
      cur <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          cur <= nxt;
          cnt <= '0;
          st  <= nxt.skip ? S_STRB : S_ADDR;
        end
        S_ADDR: if (cnt == alen_m1) begin
          cnt <= '0;
          st  <= cur.pg ? S_STRB : FULL_NEXT;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_HOLD: if (cnt == CW'(HOLD_T-1)) begin
          cnt <= '0;
          st  <= S_STRB;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: if (last) begin
          cnt <= '0;
          if (start) begin
            cur <= nxt;
            st  <= nxt.skip ? S_STRB : S_ADDR;
          end else begin
            st  <= S_IDLE;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int ADDR_FULL_T = 3,
  parameter int ADDR_PAGE_T = 2,
  parameter int HOLD_T      = 1,
  parameter int STRB_T      = 4
) (
  input  logic              clk2x,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  input  logic              page_mode,
  input  logic              idle_ale_en,
  input  logic              emi_quiet,
  output logic              rsp_done,
  output logic [BUS_W-1:0]  rsp_rdata,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              port_oe,
  output logic [BUS_W-1:0]  port_out,
  input  logic [BUS_W-1:0]  port_in,
  output logic [BUS_W-1:0]  addr_hi
);
  localparam int IDLE_PERIOD = ADDR_FULL_T + HOLD_T + STRB_T;

  st_e    st;
  frame_t cur, nxt;
  logic   last, take, hit, idle_pulse;
  kind_e  kind_in;

  assign kind_in   = (req_kind == 2'd3) ? K_DRD : kind_e'(req_kind);
  assign req_ready = !rst && ((st == S_IDLE) || last);
  assign take      = req_valid && req_ready;

  assign nxt.kind  = kind_in;
  assign nxt.pg    = page_mode && (kind_in == K_FETCH);
  assign nxt.skip  = hit;
  assign nxt.addr  = req_addr;
  assign nxt.wdata = req_wdata;

  ebs_page_track #(.HI_W(BUS_W)) u_page (
    .clk(clk2x), .rst(rst), .take(take), .is_fetch(kind_in == K_FETCH),
    .page_mode(page_mode), .hi(req_addr[ADDR_W-1 -: BUS_W]), .hit(hit)
  );

  ebs_idle_strobe #(.PERIOD(IDLE_PERIOD), .HIGH(ADDR_FULL_T)) u_idle (
    .clk(clk2x), .rst(rst), .pulse(idle_pulse)
  );

  ebs_frame_seq #(
    .ADDR_FULL(ADDR_FULL_T), .ADDR_PAGE(ADDR_PAGE_T),
    .HOLD_T(HOLD_T), .STRB_T(STRB_T)
  ) u_seq (
    .clk(clk2x), .rst(rst), .start(take), .nxt(nxt),
    .st(st), .cur(cur), .last(last)
  );

  // Response capture on the edge that ends the last strobe tick
  always_ff @(posedge clk2x) begin
    if (rst) begin
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= last;
      if (last && (cur.kind != K_DWR)) rsp_rdata <= port_in;
    end
  end

  // Bus pin drive
  always_comb begin
    if (rst)                ale = 1'b1;
    else if (st == S_ADDR)  ale = 1'b1;
    else if (st != S_IDLE)  ale = 1'b0;
    else if (emi_quiet)     ale = 1'b1;
    else                    ale = idle_ale_en && idle_pulse;
  end

  assign psen_n  = rst || !((st == S_STRB) && (cur.kind == K_FETCH));
  assign rd_n    = rst || !((st == S_STRB) && (cur.kind == K_DRD));
  assign wr_n    = rst || !((st == S_STRB) && (cur.kind == K_DWR));
  assign port_oe = !rst && ((st == S_ADDR) || (st == S_HOLD) ||
                            ((st == S_STRB) && (cur.kind == K_DWR)));
  assign port_out = (st == S_STRB) ? cur.wdata :
                    cur.pg ? cur.addr[ADDR_W-1 -: BUS_W] : cur.addr[BUS_W-1:0];
  assign addr_hi  = cur.pg ? cur.addr[BUS_W-1:0] : cur.addr[ADDR_W-1 -: BUS_W];
endmodule

// File: rtl/ext_bus_seq_chk.sv
module ext_bus_seq_chk (
  input logic clk2x,
  input logic rst,
  input logic req_ready,
  input logic rsp_done,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic port_oe
);
  AST_FETCH_PORT_RELEASED: assert property (@(posedge clk2x) disable iff (rst)
    !psen_n |-> !port_oe); // R3
  AST_ONE_STROBE: assert property (@(posedge clk2x) disable iff (rst)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk2x) disable iff (rst)
    rsp_done |=> !rsp_done); // R5
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk2x) disable iff (rst)
    rsp_done |-> $past(!psen_n || !rd_n || !wr_n)); // R5
  AST_NO_ALE_IN_STROBE: assert property (@(posedge clk2x) disable iff (rst)
    !(psen_n && rd_n && wr_n) |-> !ale); // R1
  AST_ADDR_DRIVEN: assert property (@(posedge clk2x) disable iff (rst)
    (ale && !req_ready) |-> port_oe); // R2
  AST_RESET_PINS: assert property (@(posedge clk2x)
    rst |-> (ale && !port_oe && psen_n && rd_n && wr_n && !req_ready)); // R11
endmodule

bind ext_bus_seq ext_bus_seq_chk u_chk (
  .clk2x(clk2x), .rst(rst), .req_ready(req_ready), .rsp_done(rsp_done),
  .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .port_oe(port_oe)
);

// File: tb/sim_ext_bus_seq.sv
module sim_ext_bus_seq;
  logic clk2x = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, page_mode = 1'b0, idle_ale_en = 1'b0, emi_quiet = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, port_in = '0;
  logic req_ready, rsp_done, ale, psen_n, rd_n, wr_n, port_oe;
  logic [7:0] rsp_rdata, port_out, addr_hi;

  always #2 clk2x = ~clk2x; // 250 MHz

  ext_bus_seq u0 (.*);

  typedef struct {
    bit ale, psen_n, rd_n, wr_n, oe, last, is_wr;
    bit [7:0] pout, hi, mem;
    string tag;
  } rec_t;

  rec_t q[$];
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit pg_open = 0, done_exp = 0;
  bit [7:0] pg_hi = 0, last_hi = 0, rdata_exp = 0;

  function automatic void chk(bit ok, string tag, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, expv);
    end
  endfunction

  // Builds the expected tick records of one frame from the requirements
  function automatic void push_frame(bit [1:0] k, bit [15:0] a, bit [7:0] w, string tag);
    bit [1:0] kk = (k == 2'd3) ? 2'd1 : k;
    bit pg  = page_mode && (kk == 0);
    bit hit = pg && pg_open && (a[15:8] == pg_hi);
    rec_t r;
    if (pg) begin pg_open = 1; pg_hi = a[15:8]; end else pg_open = 0;
    r.hi = pg ? a[7:0] : a[15:8];
    last_hi = r.hi;
    r.mem = a[7:0] ^ a[15:8] ^ 8'h3C;
    r.tag = tag; r.is_wr = (kk == 2);
    r.psen_n = 1; r.rd_n = 1; r.wr_n = 1; r.last = 0;
    if (!hit) begin
      r.ale = 1; r.oe = 1; r.pout = pg ? a[15:8] : a[7:0];
      for (int i = 0; i < (pg ? 2 : 3); i++) q.push_back(r);
      if (!pg) begin r.ale = 0; q.push_back(r); end
    end
    r.ale = 0; r.psen_n = (kk != 0); r.rd_n = (kk != 1); r.wr_n = (kk != 2);
    r.oe = (kk == 2); r.pout = w;
    for (int i = 0; i < 4; i++) begin r.last = (i == 3); q.push_back(r); end
  endfunction

  task automatic step(input bit v, input bit [1:0] k, input bit [15:0] a,
                      input bit [7:0] w, input string tag, output bit took);
    rec_t h;
    bit busy = (q.size() > 0);
    bit rdy  = (q.size() <= 1);
    req_valid = v; req_kind = k; req_addr = a; req_wdata = w;
    port_in = busy ? q[0].mem : 8'h00;
    #1;
    if (busy) h = q[0];
    else begin
      h.ale = emi_quiet ? 1'b1 : (idle_ale_en && (cyc % 8 < 3));
      h.psen_n = 1; h.rd_n = 1; h.wr_n = 1; h.oe = 0; h.last = 0;
      h.hi = last_hi; h.pout = 0; h.tag = "R10"; h.is_wr = 0; h.mem = 0;
    end
    chk(ale == h.ale, h.tag, "ale", ale, h.ale);
    chk(psen_n == h.psen_n, "R3", "psen_n", psen_n, h.psen_n);
    chk(rd_n == h.rd_n && wr_n == h.wr_n, "R4", "rd_n/wr_n", {rd_n, wr_n}, {h.rd_n, h.wr_n});
    chk(port_oe == h.oe, "R2", "port_oe", port_oe, h.oe);
    if (h.oe) chk(port_out == h.pout, h.tag, "port_out", port_out, h.pout);
    chk(addr_hi == h.hi, h.tag, "addr_hi", addr_hi, h.hi);
    chk(req_ready == rdy, "R6", "req_ready", req_ready, rdy);
    chk(rsp_done == done_exp, "R5", "rsp_done", rsp_done, done_exp);
    if (done_exp) chk(rsp_rdata == rdata_exp, "R5", "rsp_rdata", rsp_rdata, rdata_exp);
    took = v && rdy;
    done_exp = 0;
    if (busy) begin
      if (q[0].last) begin
        done_exp = 1;
        if (!q[0].is_wr) rdata_exp = q[0].mem;
      end
      void'(q.pop_front());
    end
    if (took) push_frame(k, a, w, tag);
    cyc++;
    @(negedge clk2x);
  endtask

  task automatic idle(input int n);
    bit t;
    for (int i = 0; i < n; i++) step(0, 0, 16'h0, 8'h0, "R10", t);
  endtask

  task automatic do_req(input bit [1:0] k, input bit [15:0] a, input bit [7:0] w, input string tag);
    bit t = 0;
    while (!t) step(1, k, a, w, tag, t);
  endtask

  task automatic do_reset(input int n);
    rst = 1; req_valid = 0;
    for (int i = 0; i < n; i++) begin
      #1;
      chk(ale == 1 && port_oe == 0, "R11", "ale/port_oe", {ale, port_oe}, 2'b10);
      chk(psen_n && rd_n && wr_n && !req_ready, "R11", "strobes/ready",
          {psen_n, rd_n, wr_n, req_ready}, 4'b1110);
      if (i > 0) chk(rsp_done == 0 && rsp_rdata == 0 && addr_hi == 0, "R11", "done/rdata/hi",
                     {rsp_done, rsp_rdata, addr_hi}, 0);
      @(negedge clk2x);
    end
    rst = 0;
    q.delete(); pg_open = 0; pg_hi = 0; last_hi = 0;
    done_exp = 0; rdata_exp = 0; cyc = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk2x);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit t;
    @(negedge clk2x);
    do_reset(4);
    // R1 R2 R3 default frames, back to back
    idle(5);
    do_req(0, 16'h1234, 8'h00, "R1");
    do_req(0, 16'h1235, 8'h00, "R1");
    // R4 data read, write, reserved kind
    do_req(1, 16'h00FF, 8'h00, "R4");
    do_req(2, 16'hABCD, 8'h5A, "R4");
    do_req(3, 16'h4411, 8'h00, "R4");
    idle(6);
    // R6 request held off, then offered mid-frame
    do_req(0, 16'h5566, 8'h00, "R6");
    step(0, 0, 0, 0, "R6", t);
    step(1, 1, 16'h7788, 8'h00, "R6", t);
    do_req(1, 16'h7788, 8'h00, "R6");
    idle(4);
    // R10 idle pulse train, then an access while enabled
    idle_ale_en = 1; idle(20);
    do_req(0, 16'h0102, 8'h00, "R1");
    idle(9);
    emi_quiet = 1; idle(6);
    do_req(2, 16'h0203, 8'hC3, "R4");
    idle(3);
    emi_quiet = 0; idle_ale_en = 0;
    // R7 R8 page mode
    page_mode = 1;
    do_req(0, 16'h2000, 8'h00, "R7");
    do_req(0, 16'h2001, 8'h00, "R8");
    do_req(0, 16'h2002, 8'h00, "R8");
    idle(3);
    do_req(0, 16'h2003, 8'h00, "R8");
    do_req(0, 16'h3000, 8'h00, "R7");
    // R9 closing the page
    do_req(1, 16'h3001, 8'h00, "R9");
    do_req(0, 16'h3002, 8'h00, "R9");
    do_req(0, 16'h3003, 8'h00, "R8");
    page_mode = 0;
    do_req(0, 16'h3004, 8'h00, "R9");
    page_mode = 1;
    do_req(0, 16'h3005, 8'h00, "R9");
    do_req(0, 16'h3006, 8'h00, "R8");
    idle(4);
    // R11 reset in the middle of a frame
    do_req(0, 16'h3007, 8'h00, "R8");
    do_req(0, 16'h9999, 8'h00, "R7");
    step(0, 0, 0, 0, "R11", t);
    do_reset(3);
    do_req(0, 16'h9999, 8'h00, "R7");
    idle(10);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule